// File: doc/BRIEF.md
# Time-Gated Transmit Fill Scheduler

This block steps through a small table of gate-control entries for one Ethernet egress port. Each entry holds a duration in clocks and an eight-bit mask of the traffic priorities that may transmit during that duration. The block opens the per-priority transmit permits to match the active entry. It counts the entry down and then fetches the next one. After the configured last entry it wraps to entry 0. Software fills the table through a simple write port while sequencing is stopped.

An entry with a non-zero duration and an empty mask is a guard window. It lets the wire drain before the next timed express frame. When fill is enabled, the block may start one short frame from a priority that was not timed in the previous window. It does so only if that frame, plus a programmable margin, ends before the guard window closes. Frame time is worked out from the requested byte length, a fixed preamble and inter-frame-gap overhead, and a per-byte clock cost picked by the link-speed input.

Fill is refused when the last non-empty mask mixed express and preemptable priorities. A separate class map says which priorities are express.

Top module: `gate_fill_sched`

## Requirements
- R1: While an entry is active, `permit` equals that entry's allow mask. `permit` is 0 in every fetch clock and whenever `run` is low. When `run` is low, `fill_busy` is also 0 and `cur_idx` returns to 0.
- R2: After `run` rises, entry 0 is fetched on the first clock edge. An entry with count N stays active for exactly N clocks. One fetch clock follows before the next entry becomes active. After the entry at index `last_idx` comes entry 0.
- R3: An entry with count 0 takes one fetch clock, never raises `permit`, and does not replace the recorded previous non-empty allow mask.
- R4: A fill grant is issued only when `fill_en` is 1 and the active entry has a non-zero count and an all-zero allow mask.
- R5: A grant requires the previous non-empty allow mask to be all express or all preemptable. Priority i is express when `express_map[i]`=1. A mixed mask, or no previous mask, blocks fill.
- R6: The frame time of priority i is (length + 20) × cost clocks. The length is `fill_len[i*11 +: 11]`. The cost is 1 when `gig_mode`=1 and 10 otherwise. `fill_busy` stays high for exactly that many clocks after a grant.
- R7: In a guard clock with R clocks left (counting that clock), a frame of F clocks is granted only if F + `fill_margin` < R. The grant pulse and `fill_busy` appear on the next clock.
- R8: A priority is eligible when it requests through `fill_req` and is absent from the previous non-empty allow mask. At most one grant, a one-hot pulse of one clock, is issued per guard window. The grant goes to the highest-numbered eligible priority whose frame fits.
- R9: `fill_busy` is 0 in every clock where `cur_idx` moves to the next entry.
- R10: After reset, `permit`, `fill_grant` and `fill_busy` are 0, and `cur_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | 4 | Table entry written |
| cfg_count | input | 16 | Duration in clocks for the written entry |
| cfg_allow | input | 8 | Allow mask for the written entry |
| last_idx | input | 4 | Index of the final entry before wrap |
| run | input | 1 | Sequencing enable; low stops and rewinds |
| fill_en | input | 1 | Enables fill in guard windows |
| fill_margin | input | 10 | Clear margin in clocks before the next entry |
| gig_mode | input | 1 | 1 = gigabit byte cost, 0 = 10/100 byte cost |
| express_map | input | 8 | Per-priority class, 1 = express |
| fill_req | input | 8 | Per-priority pending short-frame request |
| fill_len | input | 88 | Per-priority frame length in bytes, 11 bits each |
| permit | output | 8 | Per-priority transmit permit |
| fill_grant | output | 8 | One-clock one-hot fill grant |
| fill_busy | output | 1 | High while a granted fill frame occupies the wire |
| guard_active | output | 1 | Active entry is a guard window |
| cur_idx | output | 4 | Index of the entry being fetched or run |

## Verification
The bench goes after the fit boundary: one case puts frame plus margin exactly one clock under the window and one case puts it exactly at the window. A design with an off-by-one compare would grant the second case, and that frame would spill into the next timed slot. Other cases use a mixed previous mask, fill disabled, a request only from a priority that was just timed, and a slow-link frame that is too long. A design that ignored any of these conditions would grant a frame where none belongs. Further cases cover two fitting requests and a long top-priority frame beside a short lower one. These catch a design that grants twice or picks the wrong priority. A zero-count entry holding a mixed mask sits between a pure express window and a guard window. A design that recorded that mask would wrongly refuse fill, and a design that spent more than one clock on the skip would shift the grant cycle.

// File: rtl/gate_fill_sched.sv
module gate_fill_sched #(
  parameter int NPRIO    = 8,
  parameter int DEPTH    = 16,
  parameter int CNT_W    = 16,
  parameter int LEN_W    = 11,
  parameter int MARGIN_W = 10,
  parameter int OVERHEAD = 20,
  parameter int GIG_CPB  = 1,
  parameter int SLOW_CPB = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [$clog2(DEPTH)-1:0] cfg_addr,
  input  logic [CNT_W-1:0]         cfg_count,
  input  logic [NPRIO-1:0]         cfg_allow,
  input  logic [$clog2(DEPTH)-1:0] last_idx,
  input  logic                     run,
  input  logic                     fill_en,
  input  logic [MARGIN_W-1:0]      fill_margin,
  input  logic                     gig_mode,
  input  logic [NPRIO-1:0]         express_map,
  input  logic [NPRIO-1:0]         fill_req,
  input  logic [NPRIO*LEN_W-1:0]   fill_len,
  output logic [NPRIO-1:0]         permit,
  output logic [NPRIO-1:0]         fill_grant,
  output logic                     fill_busy,
  output logic                     guard_active,
  output logic [$clog2(DEPTH)-1:0] cur_idx
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int FT_W  = LEN_W + 5;
  localparam int SUM_W = (FT_W > CNT_W ? FT_W : CNT_W) + 2;

  logic [CNT_W-1:0] tbl_cnt   [DEPTH];
  logic [NPRIO-1:0] tbl_allow [DEPTH];

  always_ff @(posedge clk) begin
    if (cfg_we) begin
      tbl_cnt[cfg_addr]   <= cfg_count;
      tbl_allow[cfg_addr] <= cfg_allow;
    end
  end

  logic [IDX_W-1:0] idx;
  logic             loaded;
  logic [CNT_W-1:0] remain;
  logic [NPRIO-1:0] cur_allow;
  logic [NPRIO-1:0] last_allow;
  logic             granted;
  logic [FT_W-1:0]  busy_cnt;
  logic [NPRIO-1:0] grant_q;

  logic [IDX_W-1:0] nxt_idx;
  assign nxt_idx = (idx == last_idx || idx == IDX_W'(DEPTH - 1)) ? '0 : idx + 1'b1;

  logic guard_win, class_ok;
  assign guard_win = loaded && (cur_allow == '0);
  assign class_ok  = (last_allow != '0) &&
                     (((last_allow & ~express_map) == '0) || ((last_allow & express_map) == '0));

  logic [FT_W-1:0]  cpb;
  assign cpb = gig_mode ? FT_W'(GIG_CPB) : FT_W'(SLOW_CPB);

  logic [FT_W-1:0]  ft [NPRIO];
  logic [NPRIO-1:0] fits;
  logic [NPRIO-1:0] eligible;
  logic [NPRIO-1:0] pick;
  logic [FT_W-1:0]  pick_ft;

  assign eligible = fill_req & ~last_allow;

  always_comb begin
    pick    = '0;
    pick_ft = '0;
    for (int i = 0; i < NPRIO; i++) begin
      ft[i]   = (FT_W'(fill_len[i*LEN_W +: LEN_W]) + FT_W'(OVERHEAD)) * cpb;
      fits[i] = (SUM_W'(ft[i]) + SUM_W'(fill_margin)) < SUM_W'(remain);
      if (eligible[i] && fits[i]) begin
        pick    = NPRIO'(1) << i;
        pick_ft = ft[i];
      end
    end
  end

  logic do_grant;
  assign do_grant = run && fill_en && guard_win && class_ok && !granted && (pick != '0);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      idx        <= '0;
      loaded     <= 1'b0;
      remain     <= '0;
      cur_allow  <= '0;
      last_allow <= '0;
      granted    <= 1'b0;
      busy_cnt   <= '0;
      grant_q    <= '0;
    end else begin
      grant_q <= do_grant ? pick : '0;
      if (do_grant)            busy_cnt <= pick_ft;
      else if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;

      if (!loaded) begin
        if (tbl_cnt[idx] == '0) begin
          idx <= nxt_idx;
        end else begin
          loaded    <= 1'b1;
          remain    <= tbl_cnt[idx];
          cur_allow <= tbl_allow[idx];
          granted   <= 1'b0;
          if (tbl_allow[idx] != '0) last_allow <= tbl_allow[idx];
        end
      end else begin
        if (do_grant) granted <= 1'b1;
        if (remain == CNT_W'(1)) begin
          loaded <= 1'b0;
          idx    <= nxt_idx;
        end else begin
          remain <= remain - 1'b1;
        end
      end
    end
  end

  assign permit       = loaded ? cur_allow : '0;
  assign fill_grant   = grant_q;
  assign fill_busy    = (busy_cnt != '0);
  assign guard_active = guard_win;
  assign cur_idx      = idx;
endmodule

// File: rtl/gate_fill_sched_chk.sv
module gate_fill_sched_chk #(
  parameter int NPRIO = 8,
  parameter int DEPTH = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     run,
  input logic                     fill_en,
  input logic [NPRIO-1:0]         permit,
  input logic [NPRIO-1:0]         fill_grant,
  input logic                     fill_busy,
  input logic                     guard_active,
  input logic [$clog2(DEPTH)-1:0] cur_idx
);
  a_r8_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fill_grant));

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (|fill_grant) |=> !(|fill_grant));

  a_r4_grant_in_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (|fill_grant) |-> $past(run && fill_en && guard_active));

  a_r7_busy_follows_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (|fill_grant) |-> fill_busy);

  a_r9_wire_clear_at_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !$stable(cur_idx)) |-> !fill_busy);

  a_r1_idle_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> (permit == '0 && !fill_busy));
endmodule

bind gate_fill_sched gate_fill_sched_chk #(.NPRIO(NPRIO), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .fill_en(fill_en), .permit(permit),
  .fill_grant(fill_grant), .fill_busy(fill_busy), .guard_active(guard_active),
  .cur_idx(cur_idx)
);

// File: tb/gate_fill_sched_bench.sv
module gate_fill_sched_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [15:0] cfg_count = '0;
  logic [7:0]  cfg_allow = '0;
  logic [3:0]  last_idx = '0;
  logic        run = 1'b0;
  logic        fill_en = 1'b0;
  logic [9:0]  fill_margin = '0;
  logic        gig_mode = 1'b1;
  logic [7:0]  express_map = 8'h0F;
  logic [7:0]  fill_req = '0;
  logic [87:0] fill_len = '0;
  logic [7:0]  permit, fill_grant;
  logic        fill_busy, guard_active;
  logic [3:0]  cur_idx;

  gate_fill_sched u_gate_fill_sched (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_count(cfg_count), .cfg_allow(cfg_allow), .last_idx(last_idx),
    .run(run), .fill_en(fill_en), .fill_margin(fill_margin),
    .gig_mode(gig_mode), .express_map(express_map), .fill_req(fill_req),
    .fill_len(fill_len), .permit(permit), .fill_grant(fill_grant),
    .fill_busy(fill_busy), .guard_active(guard_active), .cur_idx(cur_idx)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] c, input logic [7:0] m);
    cfg_addr = a; cfg_count = c; cfg_allow = m; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_lens(input logic [10:0] l7, input logic [10:0] lo);
    for (int i = 0; i < 8; i++) fill_len[i*11 +: 11] = (i == 7) ? l7 : lo;
  endtask

  // en, gig, margin, prev mask, guard count, req, len7, len others, expected grant
  localparam int NV = 10;
  localparam logic [73:0] VEC [NV] = '{
    {1'b1, 1'b1, 10'd50,  8'h01, 16'd200, 8'h80, 11'd64,   11'd64, 8'h80},
    {1'b0, 1'b1, 10'd50,  8'h01, 16'd200, 8'h80, 11'd64,   11'd64, 8'h00},
    {1'b1, 1'b1, 10'd50,  8'h11, 16'd200, 8'h80, 11'd64,   11'd64, 8'h00},
    {1'b1, 1'b1, 10'd10,  8'h30, 16'd200, 8'hC0, 11'd1500, 11'd64, 8'h40},
    {1'b1, 1'b1, 10'd115, 8'h01, 16'd200, 8'h80, 11'd64,   11'd64, 8'h80},
    {1'b1, 1'b1, 10'd116, 8'h01, 16'd200, 8'h80, 11'd64,   11'd64, 8'h00},
    {1'b1, 1'b0, 10'd0,   8'h01, 16'd200, 8'h80, 11'd64,   11'd64, 8'h00},
    {1'b1, 1'b0, 10'd59,  8'h01, 16'd900, 8'h80, 11'd64,   11'd64, 8'h80},
    {1'b1, 1'b1, 10'd10,  8'h01, 16'd200, 8'h01, 11'd64,   11'd64, 8'h00},
    {1'b1, 1'b1, 10'd10,  8'h02, 16'd300, 8'hC0, 11'd64,   11'd64, 8'h80}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(permit == 0 && fill_grant == 0 && !fill_busy && cur_idx == 0,
        "R10 reset state", {permit, fill_grant}, 0);

    for (int r = 0; r < NV; r++) begin
      logic [73:0] v;
      logic        en, gg;
      logic [9:0]  mg;
      logic [7:0]  prev, rq, ex, gmask;
      logic [15:0] g;
      logic [10:0] l7, lo;
      int gcnt, bcnt, badg, f;
      v = VEC[r];
      {en, gg, mg, prev, g, rq, l7, lo, ex} = v;
      run = 1'b0;
      @(negedge clk);
      wr(4'd0, 16'd20, prev);
      wr(4'd1, g, 8'h00);
      last_idx = 4'd1; fill_en = en; gig_mode = gg; fill_margin = mg;
      fill_req = rq; set_lens(l7, lo);
      run = 1'b1;
      gmask = 0; gcnt = 0; bcnt = 0; badg = 0;
      for (int c = 1; c <= int'(g) + 23; c++) begin
        @(negedge clk);
        if (c == 1) chk(permit == prev, "R1 permit follows entry", permit, prev);
        if (c == 21) chk(permit == 0 && cur_idx == 1, "R2 fetch clock after 20", cur_idx, 1);
        if (c >= 22 && c <= 21 + int'(g) && permit != 0) badg++;
        if (fill_grant != 0) begin gmask |= fill_grant; gcnt++; end
        if (fill_busy) bcnt++;
        if (c == 22 + int'(g)) begin
          chk(cur_idx == 0, "R2 wrap after last_idx", cur_idx, 0);
          chk(!fill_busy, "R9 wire clear at next entry", fill_busy, 0);
        end
      end
      chk(badg == 0, "R1 guard permit zero", badg, 0);
      chk(gmask == ex, $sformatf("R4 R5 R7 R8 grant row %0d", r), gmask, ex);
      chk(gcnt == (ex != 0 ? 1 : 0), "R8 one grant per window", gcnt, ex != 0);
      if (ex != 0) begin
        f = (int'(ex[7] ? l7 : lo) + 20) * (gg ? 1 : 10);
        chk(bcnt == f, "R6 fill frame time", bcnt, f);
      end
    end

    run = 1'b0;
    @(negedge clk);
    wr(4'd0, 16'd10,  8'h01);
    wr(4'd1, 16'd0,   8'h11);
    wr(4'd2, 16'd200, 8'h00);
    last_idx = 4'd2; fill_en = 1'b1; gig_mode = 1'b1; fill_margin = 10'd10;
    fill_req = 8'h80; set_lens(11'd64, 11'd64);
    run = 1'b1;
    for (int c = 1; c <= 14; c++) begin
      @(negedge clk);
      if (c == 11) chk(cur_idx == 1 && permit == 0, "R3 zero entry fetched", cur_idx, 1);
      if (c == 12) chk(cur_idx == 2 && permit == 0, "R3 zero entry skipped in one clock", cur_idx, 2);
      if (c == 13) chk(guard_active && fill_grant == 0, "R7 no grant in decision clock", fill_grant, 0);
      if (c == 14) chk(fill_grant == 8'h80 && fill_busy, "R3 R7 grant after skipped mixed entry", fill_grant, 8'h80);
    end

    run = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(permit == 0 && !fill_busy && cur_idx == 0, "R1 stopped run idles", permit, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule